// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 interrupt sources into two active-low requests for a processor core. Source 0 is the fast request, and sources 1 and up feed the normal request. Each source raises its pending bit with a one-cycle set pulse. Software enables or disables each source through a mask. A source requests the core only while it is both pending and enabled.

Software reaches the block over a simple single-cycle register bus.

- Write-only command addresses set mask bits, clear mask bits, clear pending bits, and signal end of interrupt.
- Reading the vector address scans the pending bits from index 0 upward. The scan ignores the mask. The read returns the lowest pending index and acknowledges that source by clearing its bit.
- The index from the most recent vector read is kept and can be read back.
- The mask can be read at two addresses.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the pending bits, the mask bits and the stored vector are all zero. Both request outputs are high, and every readable address returns 0.
- R2: A high bit on `srcSet` during a clock edge sets the matching pending bit from that edge onward.
- R3: `fastIrqN` is low exactly while source 0 is both pending and enabled.
- R4: `normIrqN` is low exactly while at least one of sources 1 to 31 is both pending and enabled.
- R5: A write to address 8 sets the mask bits given as ones in the data. A write to address 9 clears them. All other mask bits are unchanged.
- R6: A write to address 10 clears the pending bits given as ones in the data.
- R7: A write to address 11 (end of interrupt) clears the pending bits given as ones. The request outputs reflect the change in the cycle after the write.
- R8: A read of address 0 returns the index of the lowest-numbered pending source, whether or not that source is enabled, and clears that pending bit.
- R9: A read of address 0 with nothing pending returns 0 and leaves the pending bits unchanged.
- R10: A read of address 1 returns the value that the most recent read of address 0 returned.
- R11: Reads of address 2 and of address 3 both return the current mask.
- R12: When a set pulse and a software clear target the same pending bit in the same cycle, the bit ends up set.
- R13: Read data appears on `busRdata` in the cycle after the request.
  - Reads of unassigned addresses return 0.
  - Writes to the read-only addresses 0 to 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcSet | input | 32 | One-cycle set pulses from the sources, one bit per source |
| busSel | input | 1 | Register access request |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Register word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle after a read request |
| fastIrqN | output | 1 | Active-low fast interrupt request (source 0) |
| normIrqN | output | 1 | Active-low normal interrupt request (sources 1 to 31) |

## Verification
The bench builds the block with its default of 32 sources. At that width both edges of the source range can be driven: source 0 on the fast path and source 31 at the top of the normal path. The vector scan can also be shown to return index 0 ahead of a higher pending bit. With 32 sources, the 5-bit stored vector and the zero-extended read data can be compared against indices up to 31.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADR_VEC  = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_LAST = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_MASK = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_CORE = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_EN   = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_DIS  = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_CLR  = 4'd10;
  localparam logic [ADDR_W-1:0] ADR_EOI  = 4'd11;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_VEC,
    RD_LAST,
    RD_MASK
  } rdSel_e;

  typedef struct packed {
    logic   enMask;
    logic   disMask;
    logic   clrPend;
    logic   eoi;
    logic   vecAck;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/irqc_lowest_finder.sv
module irqc_lowest_finder #(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] vecIn,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  // Scan downward so the lowest set bit is written last.
  always_comb begin
    found = |vecIn;
    idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (vecIn[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  logic wrReq;
  logic rdReq;

  assign wrReq = busSel && busWr;
  assign rdReq = busSel && !busWr;

  always_comb begin
    stb = '{enMask: 1'b0, disMask: 1'b0, clrPend: 1'b0, eoi: 1'b0,
            vecAck: 1'b0, rdSel: RD_NONE};
    if (wrReq) begin
      case (busAddr)
        ADR_EN:  stb.enMask  = 1'b1;
        ADR_DIS: stb.disMask = 1'b1;
        ADR_CLR: stb.clrPend = 1'b1;
        ADR_EOI: stb.eoi     = 1'b1;
        default: ;
      endcase
    end else if (rdReq) begin
      case (busAddr)
        ADR_VEC: begin
          stb.vecAck = 1'b1;
          stb.rdSel  = RD_VEC;
        end
        ADR_LAST: stb.rdSel = RD_LAST;
        ADR_MASK: stb.rdSel = RD_MASK;
        ADR_CORE: stb.rdSel = RD_MASK;
        default:  stb.rdSel = RD_NONE;
      endcase
    end
  end

  // At most one command strobe per cycle
  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.enMask, stb.disMask, stb.clrPend, stb.eoi, stb.vecAck})); // R13

  // Writes never acknowledge a vector
  AST_WRITE_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr) |-> !stb.vecAck); // R13
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] srcSet,
  output logic [NUM_SRC-1:0] rdata,
  output logic               fastReqN,
  output logic               normReqN
);
  localparam logic [NUM_SRC-1:0] ONE = {{(NUM_SRC-1){1'b0}}, 1'b1};

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] mask;
  logic [IDX_W-1:0]   lastVec;
  logic [NUM_SRC-1:0] active;
  logic               vecFound;
  logic [IDX_W-1:0]   vecIdx;
  logic [IDX_W-1:0]   vecOut;
  logic [NUM_SRC-1:0] ackOneHot;
  logic [NUM_SRC-1:0] swClear;

  irqc_lowest_finder #(.NUM_SRC(NUM_SRC)) uFinder (
    .vecIn(pend),
    .found(vecFound),
    .idx  (vecIdx)
  );

  assign vecOut    = vecFound ? vecIdx : '0;
  assign ackOneHot = (stb.vecAck && vecFound) ? (ONE << vecIdx) : '0;
  assign swClear   = ((stb.clrPend || stb.eoi) ? wdata : '0) | ackOneHot;

  // Pending: a set pulse beats any clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) pend <= '0;
    else       pend <= (pend & ~swClear) | srcSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            mask <= '0;
    else if (stb.enMask)  mask <= mask | wdata;
    else if (stb.disMask) mask <= mask & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           lastVec <= '0;
    else if (stb.vecAck) lastVec <= vecOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdata <= '0;
    else begin
      case (stb.rdSel)
        RD_VEC:  rdata <= NUM_SRC'(vecOut);
        RD_LAST: rdata <= NUM_SRC'(lastVec);
        RD_MASK: rdata <= mask;
        default: rdata <= '0;
      endcase
    end
  end

  assign active   = pend & mask;
  assign fastReqN = ~active[0];
  assign normReqN = ~(|active[NUM_SRC-1:1]);

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (|srcSet) |=> ((pend & $past(srcSet)) == $past(srcSet))); // R2

  AST_EN_SETS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    stb.enMask |=> ((mask & $past(wdata)) == $past(wdata))); // R5

  AST_DIS_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    stb.disMask |=> ((mask & $past(wdata)) == '0)); // R5

  AST_CLR_DROPS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrPend |=> ((pend & $past(wdata) & ~$past(srcSet)) == '0)); // R6

  AST_EOI_DROPS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    stb.eoi |=> ((pend & $past(wdata) & ~$past(srcSet)) == '0)); // R7

  AST_ACK_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vecAck && vecFound) |=> ((pend & $past(ackOneHot) & ~$past(srcSet)) == '0)); // R8

  AST_EMPTY_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vecAck && !vecFound) |=> (pend == $past(srcSet))); // R9

  AST_LAST_VEC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    stb.vecAck |=> (lastVec == $past(vecIdx))); // R10

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.enMask || stb.disMask) |=> $stable(mask)); // R13
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcSet,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [NUM_SRC-1:0] busWdata,
  output logic [NUM_SRC-1:0] busRdata,
  output logic               fastIrqN,
  output logic               normIrqN
);
  strobe_t stb;

  irqc_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .stb    (stb)
  );

  irqc_datapath #(.NUM_SRC(NUM_SRC)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wdata   (busWdata),
    .srcSet  (srcSet),
    .rdata   (busRdata),
    .fastReqN(fastIrqN),
    .normReqN(normIrqN)
  );

  // A read answers one cycle later; idle cycles return zero
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |=> (busRdata == '0)); // R13
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcSet = '0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        fastIrqN;
  logic        normIrqN;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rstN(rstN), .srcSet(srcSet), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .fastIrqN(fastIrqN), .normIrqN(normIrqN)
  );

  // Monitor: pops the expected read value one cycle after each read request
  initial begin
    forever begin
      @(posedge clk);
      if (rstN && busSel && !busWr) begin
        @(negedge clk);
        if (sbq.size() == 0) begin
          checks++; fails++;
          $display("FAIL R13: unexpected read data 0x%08h, expected none", busRdata);
        end else begin
          item_t it;
          it = sbq.pop_front();
          checks++;
          if (busRdata !== it.exp) begin
            fails++;
            $display("FAIL %s: read 0x%08h expected 0x%08h", it.req, busRdata, it.exp);
          end
        end
      end
    end
  end

  task automatic readReg(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    sbq.push_back('{exp: exp, req: req});
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d,
                          input logic [31:0] setBits = '0);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d; srcSet = setBits;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0; srcSet = '0;
  endtask

  task automatic pulse(input logic [31:0] bits);
    @(negedge clk);
    srcSet = bits;
    @(negedge clk);
    srcSet = '0;
  endtask

  task automatic checkPins(input logic expFast, input logic expNorm, input string req);
    checks++;
    if (fastIrqN !== expFast || normIrqN !== expNorm) begin
      fails++;
      $display("FAIL %s: fast/norm = %b/%b expected %b/%b", req, fastIrqN, normIrqN,
               expFast, expNorm);
    end
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkPins(1'b1, 1'b1, "R1");
    readReg(4'd0, 32'd0, "R1");
    readReg(4'd1, 32'd0, "R1");
    readReg(4'd2, 32'd0, "R1");

    // Pending but masked: no request (R2, R4)
    pulse(32'h0000_0028);
    checkPins(1'b1, 1'b1, "R4");
    writeReg(4'd8, 32'h0000_0028);
    checkPins(1'b1, 1'b0, "R4");

    readReg(4'd0, 32'd3, "R8");
    readReg(4'd1, 32'd3, "R10");
    readReg(4'd0, 32'd5, "R8");
    @(negedge clk);
    checkPins(1'b1, 1'b1, "R8");
    readReg(4'd0, 32'd0, "R9");
    readReg(4'd1, 32'd0, "R10");
    readReg(4'd2, 32'h0000_0028, "R11");
    readReg(4'd3, 32'h0000_0028, "R11");

    // Fast path and end of interrupt
    writeReg(4'd8, 32'h0000_0001);
    pulse(32'h0000_0001);
    checkPins(1'b0, 1'b1, "R3");
    writeReg(4'd11, 32'h0000_0001);
    checkPins(1'b1, 1'b1, "R7");

    // Vector scan ignores the mask
    pulse(32'h0000_0080);
    checkPins(1'b1, 1'b1, "R4");
    readReg(4'd0, 32'd7, "R8");
    readReg(4'd0, 32'd0, "R9");

    // Disable / enable, top source, clear command
    writeReg(4'd9, 32'h0000_0020);
    readReg(4'd2, 32'h0000_0009, "R5");
    writeReg(4'd8, 32'h8000_0000);
    readReg(4'd3, 32'h8000_0009, "R5");
    pulse(32'h8000_0000);
    checkPins(1'b1, 1'b0, "R2");
    writeReg(4'd10, 32'h8000_0000);
    checkPins(1'b1, 1'b1, "R6");
    readReg(4'd0, 32'd0, "R6");

    // Set and clear on the same bit in the same cycle
    writeReg(4'd10, 32'h0000_0004, 32'h0000_0004);
    readReg(4'd0, 32'd2, "R12");

    // Unassigned read and write to a read-only address
    readReg(4'd5, 32'd0, "R13");
    writeReg(4'd2, 32'hFFFF_FFFF);
    readReg(4'd2, 32'h8000_0009, "R13");

    // Source 0 scanned ahead of source 9, both outputs low together
    writeReg(4'd8, 32'h0000_0200);
    pulse(32'h0000_0201);
    checkPins(1'b0, 1'b0, "R3");
    readReg(4'd0, 32'd0, "R8");
    readReg(4'd1, 32'd0, "R10");
    checkPins(1'b1, 1'b0, "R3");
    readReg(4'd0, 32'd9, "R8");
    readReg(4'd1, 32'd9, "R10");
    checkPins(1'b1, 1'b1, "R4");

    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      checks++; fails++;
      $display("FAIL R13: %0d reads unanswered, expected 0", sbq.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule